// File: doc/BRIEF.md
# Page Write Controller with Toggle Polling

This block sits behind the bus front end of a byte-wide non-volatile memory. It collects a burst of byte writes that all fall in one page into a page buffer. Once no further write has arrived for a set load window, it runs a timed programming cycle. That cycle commits the loaded bytes to the storage array through a simple write port. While programming runs, the block reports busy, and every read returns a status bit in place of data bit 6. That status bit flips on each read, so software can poll for the end of the write.

Inputs are single-cycle write events carrying a full address and a data byte, and single-cycle read events. Both are already qualified by the bus front end. All timing is counted in clock cycles. The load window is `LOAD_CYC` cycles long. Each accepted write restarts it. The programming cycle lasts `PAGE_N + PROG_CYC` cycles, counted from the first cycle of the commit sweep. The state machine has four states:

- `ST_IDLE`: no burst is open.
- `ST_LOAD`: the burst is open and the load window is running.
- `ST_COMMIT`: one cycle per page offset, sweeping the buffer into the array.
- `ST_SETTLE`: the remaining programming time.

Its transitions are:

- IDLE to LOAD on the first accepted write.
- LOAD to LOAD on each further write to the same page, which restarts the window.
- LOAD to COMMIT when the window expires.
- COMMIT to SETTLE after the last offset.
- SETTLE to IDLE when the programming time expires. This transition also clears the buffer.

Top module: `page_write_ctrl`

## Requirements
- R1: After reset, `busy`, `arr_we` and `ovr_en` are low.
- R2: A write accepted while not busy stores its data byte at page offset `wr_addr[6:0]`. A later accepted write to the same offset in the same burst replaces the earlier byte.
- R3: The first write of a burst fixes the page tag `wr_addr[14:7]`. A later write whose tag differs is ignored and is never committed.
- R4: Every accepted write restarts the load window. Programming starts exactly `LOAD_CYC` cycles after the clock edge that accepted the last write. `busy` is first seen high after that edge.
- R5: The commit sweep visits offsets 0 to 127 in ascending order, one per cycle. It pulses `arr_we` only for offsets loaded in the burst, with `arr_addr` = {page tag, offset} and `arr_data` = the last byte loaded there.
- R6: `busy` stays high for exactly `PAGE_N + PROG_CYC` cycles, then falls.
- R7: A write that arrives while `busy` is high is ignored. It is not committed in the current cycle or in any later cycle.
- R8: `ovr_en` equals `busy`. Each read event while busy inverts `poll_bit`, which is the value to drive on data bit 6. The first read of a programming cycle gives 1, the next gives 0, and so on.
- R9: After programming ends, `ovr_en` is low, reads have no override, and a new burst is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_evt | input | 1 | One-cycle pulse marking a write strobe falling edge |
| wr_addr | input | ADDR_W (15) | Write byte address |
| wr_data | input | DATA_W (8) | Write data byte |
| rd_evt | input | 1 | One-cycle pulse per read access |
| busy | output | 1 | Programming cycle in progress |
| arr_we | output | 1 | Array write strobe |
| arr_addr | output | ADDR_W (15) | Array write address |
| arr_data | output | DATA_W (8) | Array write data |
| ovr_en | output | 1 | Read data bit 6 is replaced by `poll_bit` |
| poll_bit | output | 1 | Toggling status bit for polled reads |

## Verification
A wrong state or timer value shows up at `busy`. Its rising edge comes one or more cycles off from `LOAD_CYC` after the last accepted write, or its width differs from `PAGE_N + PROG_CYC`. Both are checked to the exact cycle. A wrong page buffer or a sweep index error shows up within the same programming cycle: a missing, extra, out-of-order or wrongly addressed `arr_we` pulse, compared against a page image the bench builds from the writes. A stale valid bit is left over from a write made while busy. That error only appears one burst later, as an extra commit, so the bench runs a follow-up burst to catch it.

// File: rtl/pwc_pkg.sv
package pwc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOAD   = 2'd1,
        ST_COMMIT = 2'd2,
        ST_SETTLE = 2'd3
    } pwc_state_e;
endpackage

// File: rtl/pwc_timer.sv
// Loadable down counter; done is high in the last counted cycle.
module pwc_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == CNT_W'(1));

    AST_TIMER_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0 && !load) |=> (cnt_q == '0)); // R4
endmodule

// File: rtl/pwc_page_buf.sv
// Page-sized byte buffer with one loaded flag per offset.
module pwc_page_buf #(
    parameter int DATA_W = 8,
    parameter int IDX_W  = 7,
    localparam int PAGE_N = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              clr,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic [PAGE_N-1:0] valid_vec
);
    logic [DATA_W-1:0] mem_q [PAGE_N];

    for (genvar g = 0; g < PAGE_N; g++) begin : g_entry
        logic hit;
        assign hit = wr_en && (wr_idx == IDX_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                valid_vec[g] <= 1'b0;
            end else if (clr) begin
                valid_vec[g] <= 1'b0;
            end else if (hit) begin
                valid_vec[g] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (hit) begin
                mem_q[g] <= wr_data;
            end
        end
    end

    assign rd_data  = mem_q[rd_idx];
    assign rd_valid = valid_vec[rd_idx];

    AST_WRITE_MARKS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clr) |=> valid_vec[$past(wr_idx)]); // R2
endmodule

// File: rtl/pwc_poll.sv
// Status bit that inverts on each read while programming runs.
module pwc_poll (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic busy,
    input  logic rd_evt,
    output logic poll_bit
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            poll_bit <= 1'b0;
        end else if (arm) begin
            poll_bit <= 1'b0;
        end else if (busy && rd_evt) begin
            poll_bit <= ~poll_bit;
        end
    end

    AST_POLL_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rd_evt && !arm) |=> (poll_bit != $past(poll_bit))); // R8
    AST_POLL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !arm) |=> $stable(poll_bit)); // R9
endmodule

// File: rtl/page_write_ctrl.sv
module page_write_ctrl
    import pwc_pkg::*;
#(
    parameter int ADDR_W   = 15,
    parameter int DATA_W   = 8,
    parameter int IDX_W    = 7,
    parameter int LOAD_CYC = 20000,
    parameter int PROG_CYC = 999872
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_evt,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_evt,
    output logic              busy,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [DATA_W-1:0] arr_data,
    output logic              ovr_en,
    output logic              poll_bit
);
    localparam int PAGE_N = 1 << IDX_W;
    localparam int TAG_W  = ADDR_W - IDX_W;
    localparam int T_MAX  = (LOAD_CYC > PROG_CYC) ? LOAD_CYC : PROG_CYC;
    localparam int CNT_W  = $clog2(T_MAX + 1);

    pwc_state_e        state_q, state_d;
    logic [TAG_W-1:0]  page_q;
    logic [IDX_W-1:0]  idx_q;
    logic              page_hit, acc_wr, sweep_last;
    logic              tmr_load, tmr_done, buf_clr, poll_arm;
    logic [CNT_W-1:0]  tmr_val;
    logic [DATA_W-1:0] buf_rd_data;
    logic              buf_rd_valid;
    logic [PAGE_N-1:0] valid_vec;

    assign page_hit   = (wr_addr[ADDR_W-1:IDX_W] == page_q);
    assign acc_wr     = wr_evt && ((state_q == ST_IDLE) ||
                                   (state_q == ST_LOAD && page_hit));
    assign sweep_last = (idx_q == IDX_W'(PAGE_N - 1));
    assign tmr_load   = acc_wr || (state_q == ST_COMMIT && sweep_last);
    assign tmr_val    = acc_wr ? CNT_W'(LOAD_CYC) : CNT_W'(PROG_CYC);
    assign buf_clr    = (state_q == ST_SETTLE) && tmr_done;
    assign poll_arm   = (state_q == ST_LOAD) && (state_d == ST_COMMIT);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (acc_wr) state_d = ST_LOAD;
            ST_LOAD:   if (!acc_wr && tmr_done) state_d = ST_COMMIT;
            ST_COMMIT: if (sweep_last) state_d = ST_SETTLE;
            ST_SETTLE: if (tmr_done) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Page tag and sweep index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_q <= '0;
            idx_q  <= '0;
        end else begin
            if (state_q == ST_IDLE && wr_evt) begin
                page_q <= wr_addr[ADDR_W-1:IDX_W];
            end
            if (state_q == ST_COMMIT) begin
                idx_q <= idx_q + 1'b1;
            end else begin
                idx_q <= '0;
            end
        end
    end

    // Outputs
    always_comb begin
        busy     = 1'b0;
        arr_we   = 1'b0;
        arr_addr = {page_q, idx_q};
        arr_data = buf_rd_data;
        unique case (state_q)
            ST_IDLE, ST_LOAD: busy = 1'b0;
            ST_COMMIT: begin
                busy   = 1'b1;
                arr_we = buf_rd_valid;
            end
            ST_SETTLE: busy = 1'b1;
            default:   busy = 1'b0;
        endcase
        ovr_en = busy;
    end

    pwc_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    pwc_page_buf #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (acc_wr),
        .wr_idx    (wr_addr[IDX_W-1:0]),
        .wr_data   (wr_data),
        .clr       (buf_clr),
        .rd_idx    (idx_q),
        .rd_data   (buf_rd_data),
        .rd_valid  (buf_rd_valid),
        .valid_vec (valid_vec)
    );

    pwc_poll u_poll (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm      (poll_arm),
        .busy     (busy),
        .rd_evt   (rd_evt),
        .poll_bit (poll_bit)
    );

    AST_SWEEP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COMMIT && $past(state_q == ST_COMMIT))
        |-> (idx_q == IDX_W'($past(idx_q) + 1'b1))); // R5
    AST_IDLE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (valid_vec == '0)); // R7
    AST_LOAD_HAS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOAD) |-> (valid_vec != '0)); // R2
    AST_BUSY_BLOCKS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_evt && !buf_clr) |=> $stable(valid_vec)); // R7
    AST_COMMIT_FROM_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(state_q) == ST_LOAD)); // R4
endmodule

// File: tb/test_page_write_ctrl.sv
module test_page_write_ctrl;
    localparam int ADDR_W = 15;
    localparam int DATA_W = 8;
    localparam int IDX_W  = 7;
    localparam int PAGE_N = 1 << IDX_W;
    localparam int LOAD_C = 20;
    localparam int PROG_C = 40;
    localparam int BUSY_C = PAGE_N + PROG_C;
    localparam int NVEC   = 6;
    // {page tag, offset, data}
    localparam logic [22:0] WR_VEC [NVEC] = '{
        {8'h2A, 7'd5,   8'h11},
        {8'h2A, 7'd0,   8'h22},
        {8'h13, 7'd9,   8'h33},
        {8'h2A, 7'd127, 8'h44},
        {8'h2A, 7'd5,   8'h55},
        {8'h2A, 7'd64,  8'h66}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_evt = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic rd_evt = 1'b0;
    logic busy, arr_we, ovr_en, poll_bit;
    logic [ADDR_W-1:0] arr_addr;
    logic [DATA_W-1:0] arr_data;

    int tests = 0;
    int fails = 0;
    bit done_flag = 1'b0;

    logic       ex_valid [PAGE_N];
    logic [7:0] ex_data  [PAGE_N];
    logic       lg_valid [PAGE_N];
    logic [7:0] lg_data  [PAGE_N];
    logic [7:0] lg_page_exp;
    int lg_cnt, lg_bad_page, lg_order_bad, lg_last;

    always #2.5 clk = ~clk;

    page_write_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W),
        .LOAD_CYC(LOAD_C), .PROG_CYC(PROG_C)
    ) i_page_write_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_evt(wr_evt), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_evt(rd_evt), .busy(busy), .arr_we(arr_we),
        .arr_addr(arr_addr), .arr_data(arr_data), .ovr_en(ovr_en),
        .poll_bit(poll_bit)
    );

    // Array write monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n && arr_we) begin
            if (arr_addr[14:7] != lg_page_exp) lg_bad_page++;
            if (lg_cnt > 0 && int'(arr_addr[6:0]) <= lg_last) lg_order_bad++;
            lg_last = int'(arr_addr[6:0]);
            lg_valid[arr_addr[6:0]] = 1'b1;
            lg_data[arr_addr[6:0]]  = arr_data;
            lg_cnt++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] pg, input logic [6:0] off, input logic [7:0] d);
        @(negedge clk);
        wr_evt = 1'b1; wr_addr = {pg, off}; wr_data = d;
        @(negedge clk);
        wr_evt = 1'b0;
    endtask

    task automatic rd();
        @(negedge clk);
        rd_evt = 1'b1;
        @(negedge clk);
        rd_evt = 1'b0;
    endtask

    task automatic clear_exp(input logic [7:0] pg);
        for (int i = 0; i < PAGE_N; i++) begin
            ex_valid[i] = 1'b0; ex_data[i] = '0;
            lg_valid[i] = 1'b0; lg_data[i] = '0;
        end
        lg_page_exp = pg; lg_cnt = 0; lg_bad_page = 0;
        lg_order_bad = 0; lg_last = -1;
    endtask

    // Called right after the last accepted write; checks the window edge.
    task automatic check_start(input string req);
        cyc(LOAD_C - 1);
        chk(busy == 1'b0, req, busy, 0);
        cyc(1);
        chk(busy == 1'b1, req, busy, 1);
    endtask

    task automatic check_image(input string req);
        int mism = 0;
        for (int i = 0; i < PAGE_N; i++) begin
            if (lg_valid[i] != ex_valid[i]) mism++;
            else if (ex_valid[i] && lg_data[i] != ex_data[i]) mism++;
        end
        chk(mism == 0, req, mism, 0);
        chk(lg_bad_page == 0, req, lg_bad_page, 0);
        chk(lg_order_bad == 0, req, lg_order_bad, 0);
    endtask

    initial begin
        int used;
        logic [7:0] first_pg;
        cyc(3);
        // R1: reset state
        chk(busy == 1'b0, "R1 busy", busy, 0);
        chk(arr_we == 1'b0, "R1 arr_we", arr_we, 0);
        chk(ovr_en == 1'b0, "R1 ovr_en", ovr_en, 0);
        rst_n = 1'b1;
        cyc(2);

        // Table walk: R2 overwrite, R3 foreign page, R4 retrigger
        first_pg = WR_VEC[0][22:15];
        clear_exp(first_pg);
        for (int v = 0; v < NVEC; v++) begin
            if (WR_VEC[v][22:15] == first_pg) begin
                ex_valid[WR_VEC[v][14:8]] = 1'b1;
                ex_data[WR_VEC[v][14:8]]  = WR_VEC[v][7:0];
            end
            wr(WR_VEC[v][22:15], WR_VEC[v][14:8], WR_VEC[v][7:0]);
            if (v != NVEC - 1) begin
                chk(busy == 1'b0, "R4 no start mid burst", busy, 0);
                cyc(3);
            end
        end
        check_start("R4 window after last write");
        used = 0;
        // R8: polled reads flip, first gives 1
        chk(ovr_en == 1'b1, "R8 ovr_en while busy", ovr_en, 1);
        rd(); used += 2;
        chk(poll_bit == 1'b1, "R8 first poll", poll_bit, 1);
        rd(); used += 2;
        chk(poll_bit == 1'b0, "R8 second poll", poll_bit, 0);
        rd(); used += 2;
        chk(poll_bit == 1'b1, "R8 third poll", poll_bit, 1);
        // R7: write during commit sweep
        wr(first_pg, 7'd10, 8'h77); used += 2;
        cyc(PAGE_N + 5 - used); used = PAGE_N + 5;
        // R7: write during settle
        wr(first_pg, 7'd11, 8'h78); used += 2;
        cyc(BUSY_C - 1 - used);
        chk(busy == 1'b1, "R6 busy held", busy, 1);
        cyc(1);
        chk(busy == 1'b0, "R6 busy falls", busy, 0);
        chk(ovr_en == 1'b0, "R9 ovr_en after end", ovr_en, 0);
        check_image("R5 R3 R2 R7 commit image");

        // R9 idle read: no override
        rd();
        chk(ovr_en == 1'b0, "R9 read while idle", ovr_en, 0);

        // Single byte burst; stale busy writes must not appear (R7)
        clear_exp(8'h01);
        ex_valid[3] = 1'b1; ex_data[3] = 8'hC3;
        wr(8'h01, 7'd3, 8'hC3);
        check_start("R9 new burst accepted");
        rd();
        chk(poll_bit == 1'b1, "R8 poll rearmed", poll_bit, 1);
        cyc(BUSY_C - 2);
        chk(busy == 1'b0, "R6 single burst end", busy, 0);
        chk(lg_cnt == 1, "R7 single commit count", lg_cnt, 1);
        check_image("R5 single byte");

        // Full page, back to back
        clear_exp(8'h7F);
        for (int i = 0; i < PAGE_N; i++) begin
            ex_valid[i] = 1'b1; ex_data[i] = 8'(i) ^ 8'hA5;
            wr(8'h7F, 7'(i), 8'(i) ^ 8'hA5);
        end
        check_start("R4 full page start");
        cyc(BUSY_C);
        chk(busy == 1'b0, "R6 full page end", busy, 0);
        chk(lg_cnt == PAGE_N, "R5 full page count", lg_cnt, PAGE_N);
        check_image("R5 full page");

        done_flag = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(100000 * 5);
        if (!done_flag) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule